// File: doc/BRIEF.md
# Double-Buffered Attenuation Register Bank

This block holds the digital attenuation settings for a set of DAC channels (two by default, left and right). Each channel has a pair of registers: a staging register that takes newly written codes, and an active register whose contents drive the block's outputs. The gain curve for the audio samples is applied elsewhere. Attenuation codes are 8 bits wide and count in 0.5 dB steps. The all-ones code stands for 0 dB.

A write has a 7-bit address and a 9-bit data word. Bits 7:0 of the data carry the code. Bit 8 is a commit flag. When the commit flag is set, every channel's staging value is copied into its active register on the same clock edge. The commit flag itself is never stored. One master address loads the staging register of every channel at once. A one-cycle change pulse appears in any cycle where an active code has just taken a new value.

Top module: `att_bank`

## Requirements
- R1: While reset is held, and on the first cycle after it, every staging and active code reads 8'hFF and the change pulse is low.
- R2: A write to channel address i (left = 7'h00, right = 7'h01) with data bit 8 = 0 loads data[7:0] into channel i's staging register only. No active code changes, and no pulse is raised.
- R3: A write to channel address i with data bit 8 = 1 sets active code i to data[7:0]. On the same edge, every other channel's active code takes that channel's staging value.
- R4: A write to the master address 7'h08 with data bit 8 = 0 loads data[7:0] into the staging register of every channel. The active codes are left as they were.
- R5: A write to the master address 7'h08 with data bit 8 = 1 sets every active code to data[7:0] on one edge.
- R6: A write to any other address, whatever its bit 8, changes no staging or active register. So does a cycle with the write enable low.
- R7: The commit flag is not retained. After a commit, a later write with bit 8 = 0 leaves the active codes unchanged.
- R8: The change pulse is high for exactly the cycle in which at least one active code first shows a new value. A commit that leaves every active code at its old value raises no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 7 | Write address |
| wr_data | input | 9 | Bit 8 is the commit flag, bits 7:0 are the code |
| active_code | output | NUM_CH x 8 | Active attenuation code per channel; element 0 is left |
| chg_pulse | output | 1 | High for one cycle after an active code changes |

## Verification
The bench stages a code on one channel and then commits through a write to the other channel. A design that commits only the addressed channel would leave the first channel's active code stale.

It sends writes with the commit flag set to unused addresses, and then commits through a valid channel. A design that decodes the address loosely would either change the outputs early or overwrite a staged value, and either one shows up at the next commit.

It commits codes equal to the current active codes to check that no pulse is raised. It also repeats a write without the flag after a commit, which catches a design that latches the flag.

// File: rtl/att_bank_pkg.sv
package att_bank_pkg;

    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 9;
    localparam int CODE_W   = 8;
    localparam int UPD_BIT  = 8;

    localparam logic [ADDR_W-1:0] MASTER_ADDR = 7'h08;
    localparam logic [CODE_W-1:0] RST_CODE    = 8'hFF;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic              upd;
        code_t             code;
    } wr_cmd_t;

    // channel i sits at address i
    function automatic logic [ADDR_W-1:0] chan_addr(input int idx);
        return ADDR_W'(idx);
    endfunction

    function automatic wr_cmd_t pack_cmd(input logic en,
                                         input logic [ADDR_W-1:0] addr,
                                         input logic [DATA_W-1:0] data);
        wr_cmd_t c;
        c.en   = en;
        c.addr = addr;
        c.upd  = data[UPD_BIT];
        c.code = data[CODE_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/att_wr_decode.sv
module att_wr_decode
    import att_bank_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  wr_cmd_t           cmd,
    output logic [NUM_CH-1:0] stage_we,
    output code_t             stage_code,
    output logic              commit
);

    logic [NUM_CH-1:0] hit_ch;
    logic              hit_master;

    assign hit_master = (cmd.addr == MASTER_ADDR);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign hit_ch[i]   = (cmd.addr == chan_addr(i));
        assign stage_we[i] = cmd.en && (hit_ch[i] || hit_master);
    end

    assign stage_code = cmd.code;
    assign commit     = cmd.en && cmd.upd && (hit_master || (|hit_ch));

endmodule

// File: rtl/att_channel.sv
module att_channel
    import att_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stage_we,
    input  code_t stage_code,
    input  logic  commit,
    output code_t active,
    output logic  will_change
);

    code_t staged;
    code_t next_act;

    always_comb begin
        next_act    = stage_we ? stage_code : staged;
        will_change = commit && (next_act != active);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= RST_CODE;
            active <= RST_CODE;
        end else begin
            if (stage_we) staged <= stage_code;
            if (commit)   active <= next_act;
        end
    end

endmodule

// File: rtl/att_change_pulse.sv
module att_change_pulse #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] will_change,
    output logic              pulse
);

    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= |will_change;
    end

endmodule

// File: rtl/att_bank.sv
module att_bank
    import att_bank_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_CH-1:0][CODE_W-1:0]  active_code,
    output logic                           chg_pulse
);

    wr_cmd_t           cmd;
    logic [NUM_CH-1:0] stage_we;
    code_t             stage_code;
    logic              commit;
    logic [NUM_CH-1:0] will_change;

    assign cmd = pack_cmd(wr_en, wr_addr, wr_data);

    att_wr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .cmd        (cmd),
        .stage_we   (stage_we),
        .stage_code (stage_code),
        .commit     (commit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        att_channel u_ch (
            .clk         (clk),
            .rst         (rst),
            .stage_we    (stage_we[i]),
            .stage_code  (stage_code),
            .commit      (commit),
            .active      (active_code[i]),
            .will_change (will_change[i])
        );
    end

    att_change_pulse #(.NUM_CH(NUM_CH)) u_pulse (
        .clk         (clk),
        .rst         (rst),
        .will_change (will_change),
        .pulse       (chg_pulse)
    );

endmodule

// File: rtl/att_bank_checker.sv
module att_bank_checker
    import att_bank_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic [NUM_CH-1:0][CODE_W-1:0] active_code,
    input logic                          chg_pulse
);

    logic known_addr;
    always_comb begin
        known_addr = (wr_addr == MASTER_ADDR);
        for (int i = 0; i < NUM_CH; i++)
            if (wr_addr == chan_addr(i)) known_addr = 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (active_code == {NUM_CH{RST_CODE}}) && !chg_pulse);

    assert_stage_only_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[UPD_BIT]) |=> $stable(active_code));

    assert_foreign_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || !known_addr) |=> $stable(active_code));

    assert_pulse_tracks_change_R8: assert property (@(posedge clk) disable iff (rst)
        chg_pulse == (active_code != $past(active_code)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_direct_commit_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_data[UPD_BIT] && wr_addr == chan_addr(i))
            |=> active_code[i] == $past(wr_data[CODE_W-1:0]));

        assert_master_commit_R5: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_data[UPD_BIT] && wr_addr == MASTER_ADDR)
            |=> active_code[i] == $past(wr_data[CODE_W-1:0]));
    end

endmodule

bind att_bank att_bank_checker #(.NUM_CH(NUM_CH)) u_att_bank_checker (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .active_code (active_code),
    .chg_pulse   (chg_pulse)
);

// File: tb/att_bank_test.sv
module att_bank_test;

    localparam int NCH = 2;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      wr_en = 1'b0;
    logic [6:0]                wr_addr = '0;
    logic [8:0]                wr_data = '0;
    logic [NCH-1:0][7:0]       active_code;
    logic                      chg_pulse;

    int n_vec  = 0;
    int n_fail = 0;

    logic [7:0] m_stage [NCH];
    logic [7:0] m_act   [NCH];
    logic       m_pulse;

    always #10 clk = ~clk;

    att_bank #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .active_code(active_code), .chg_pulse(chg_pulse)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NCH; i++)
            chk(req, $sformatf("active[%0d]", i), 16'(active_code[i]), 16'(m_act[i]));
        chk(req, "pulse", 16'(chg_pulse), 16'(m_pulse));
    endtask

    // expected effect of one write, from the requirements
    task automatic model(input logic [6:0] a, input logic [8:0] d);
        logic [7:0] old_act [NCH];
        logic known = (a == 7'h08) || (a < 7'(NCH));
        for (int i = 0; i < NCH; i++) old_act[i] = m_act[i];
        if (known) begin
            for (int i = 0; i < NCH; i++)
                if (a == 7'h08 || a == 7'(i)) m_stage[i] = d[7:0];
            if (d[8])
                for (int i = 0; i < NCH; i++) m_act[i] = m_stage[i];
        end
        m_pulse = 1'b0;
        for (int i = 0; i < NCH; i++)
            if (m_act[i] != old_act[i]) m_pulse = 1'b1;
    endtask

    task automatic wr(input string req, input logic [6:0] a, input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model(a, d);
        check_all(req);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        @(posedge clk); #1;
        m_pulse = 1'b0;
        check_all(req);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NCH; i++) begin m_stage[i] = 8'hFF; m_act[i] = 8'hFF; end
        m_pulse = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1; check_all("R1");
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1; check_all("R1");
        // staged reset value visible after a commit of the other channel
        wr("R1", 7'h01, 9'h1FF);
    endtask

    task automatic t_stage_only;
        wr("R2", 7'h00, 9'h012);
        wr("R2", 7'h01, 9'h034);
        idle("R2");
    endtask

    task automatic t_commit_channel;
        wr("R3", 7'h01, 9'h156);   // left takes its staged 0x12
        idle("R8");
        wr("R3", 7'h00, 9'h005);
        wr("R3", 7'h00, 9'h1A0);   // left direct, right keeps 0x56
    endtask

    task automatic t_flag_not_kept;
        wr("R7", 7'h00, 9'h077);
        idle("R7");
        wr("R7", 7'h01, 9'h088);
        idle("R7");
    endtask

    task automatic t_master;
        wr("R4", 7'h08, 9'h040);
        idle("R4");
        wr("R4", 7'h01, 9'h100 | 9'(m_stage[1]));   // commits master-staged values
        wr("R5", 7'h08, 9'h1C3);
        idle("R8");
    endtask

    task automatic t_foreign;
        wr("R6", 7'h00, 9'h011);
        wr("R6", 7'h02, 9'h155);
        wr("R6", 7'h09, 9'h122);
        wr("R6", 7'h48, 9'h133);
        wr("R6", 7'h7F, 9'h000);
        @(negedge clk);            // strobe low with commit pattern on the bus
        wr_addr = 7'h08; wr_data = 9'h1EE;
        @(posedge clk); #1;
        m_pulse = 1'b0; check_all("R6");
        wr("R6", 7'h01, 9'h121);   // left must reveal 0x11
    endtask

    task automatic t_same_value;
        wr("R8", 7'h08, 9'h1C3);   // same as... first set known
        wr("R8", 7'h08, 9'h1C3);   // no change, no pulse
        wr("R8", 7'h00, 9'h1C3);
        idle("R8");
    endtask

    initial begin
        t_reset();
        t_stage_only();
        t_commit_channel();
        t_flag_not_kept();
        t_master();
        t_foreign();
        t_same_value();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_vec++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule